// File: doc/BRIEF.md
# Stereo Ramping Volume Stage with Zero-Cross Gating

This block scales a stereo stream of 16-bit signed samples by an attenuation coefficient. The coefficient ranges from 0 (silence) to 256 (unity gain). One left/right sample pair arrives with each pulse of `frame_stb`. Each output sample is the product of the input sample and that channel's coefficient, shifted right arithmetically by 8 and limited to 16 bits. The result is registered and comes out one cycle after the strobe.

A shared level register moves toward a target level by one code per frame. Two commands set the target for a slow fade: `cmd_up` aims at unity and `cmd_down` aims at silence. If the target changes during a fade, the fade turns from wherever the level currently is. `cmd_set` jumps both level and target straight to `att_code`; for example, code 60 gives about -12 dB. The `mute` input holds the target at zero and blocks every command while it is high, so the level fades out.

Each channel takes the shared level only at a quiet point in its own signal. That happens on a frame whose sample has its top 7 bits all equal, which means the sample lies within ±512 of zero. Until then the channel keeps its old coefficient, so gain changes never land on a large sample.

Top module: `stereo_fade_att`

## Requirements
- R1: While `rst_n` is low and until the first frame after reset, `out_l`, `out_r` and `out_vld` are 0. The level, the target and both channel coefficients reset to 256 (unity).
- R2: For a frame strobe on cycle N, each output on cycle N+1 equals floor(sample × coef / 256), with a signed sample and an arithmetic shift. A coefficient of 256 passes the sample through unchanged.
- R3: On each frame strobe with no direct set in that cycle, the level moves one code toward the target. When the level equals the target, it stays put until a command changes the target.
- R4: `cmd_up` sets the target to 256 and `cmd_down` sets it to 0, taking effect on the next clock edge. The priority is `cmd_set` over `cmd_up` over `cmd_down`. A new target during a fade continues the fade from the current level.
- R5: `cmd_set` loads both the level and the target with `att_code` at the next clock edge, with no ramp. Codes above 256 are clamped to 256.
- R6: On a frame strobe, a channel adopts the current level (the value before that frame's step) only when bits [15:9] of its sample are all 0 or all 1. Otherwise it keeps its previous coefficient. The two channels decide independently.
- R7: While `mute` is high, the target is forced to 0 and `cmd_set`, `cmd_up` and `cmd_down` are ignored. A coefficient of 0 yields output 0 for any sample.
- R8: `out_vld` is high exactly in the cycle after a frame strobe. `out_l` and `out_r` change only in that cycle and hold their value otherwise.
- R9: The magnitude of an output sample never exceeds the magnitude of the sample it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per stereo frame; `in_l`/`in_r` are valid on it |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| cmd_up | input | 1 | Fade toward unity (target 256) |
| cmd_down | input | 1 | Fade toward silence (target 0) |
| cmd_set | input | 1 | Load `att_code` immediately into level and target |
| att_code | input | 9 | Coefficient for `cmd_set`, 0..256 (larger values clamp) |
| mute | input | 1 | Force target to 0, block commands |
| out_l | output | 16 | Left scaled sample, signed |
| out_r | output | 16 | Right scaled sample, signed |
| out_vld | output | 1 | High in the cycle the outputs update |

## Verification
Random frames draw samples from two classes: small values inside the ±512 quiet band and full-range values outside it. This separates a channel that adopts the level on every frame from one that waits for a quiet sample. It also shows whether the two channels gate independently. Full fades in both directions, reversals in the middle of a fade, and direct sets alongside mute pulses show whether the level steps once per frame, turns from its current value, and ignores commands under mute. Directed frames use extreme values such as -32768, -1 and unity gain. Together with code 60, these test the rounding direction of the arithmetic shift and the bound on output magnitude.

// File: rtl/fade_att_pkg.sv
package fade_att_pkg;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_RISE = 2'd1,
        RAMP_FALL = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/fade_level_ctrl.sv
module fade_level_ctrl
    import fade_att_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          cmd_up,
    input  logic          cmd_down,
    input  logic          cmd_set,
    input  logic [CW-1:0] att_code,
    input  logic          mute,
    output logic [CW-1:0] level
);
    localparam logic [CW-1:0] UNITY = CW'(1) << (CW - 1);

    typedef struct packed {
        logic [CW-1:0] target;
        logic [CW-1:0] level;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;
    logic [CW-1:0] code_c;
    logic          set_eff;

    always_comb begin
        code_c  = (att_code > UNITY) ? UNITY : att_code;
        set_eff = cmd_set && !mute;
        if (st_q.level < st_q.target)      dir = RAMP_RISE;
        else if (st_q.level > st_q.target) dir = RAMP_FALL;
        else                               dir = RAMP_HOLD;

        st_d = st_q;
        if (frame_stb && !set_eff) begin
            case (dir)
                RAMP_RISE: st_d.level = st_q.level + CW'(1);
                RAMP_FALL: st_d.level = st_q.level - CW'(1);
                default:   st_d.level = st_q.level;
            endcase
        end
        if (mute) begin
            st_d.target = '0;
        end else if (cmd_set) begin
            st_d.target = code_c;
            st_d.level  = code_c;
        end else if (cmd_up) begin
            st_d.target = UNITY;
        end else if (cmd_down) begin
            st_d.target = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.target <= UNITY;
            st_q.level  <= UNITY;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;

    // R3: level never moves by more than one code without a direct set
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_set && !mute) |=>
            ((st_q.level == $past(st_q.level)) ||
             (st_q.level == $past(st_q.level) + CW'(1)) ||
             (st_q.level == $past(st_q.level) - CW'(1))));

    // R3: settled level stays when no frame or no command changes anything
    a_r3_hold_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level == st_q.target && !cmd_set && !cmd_up && !cmd_down && !mute)
            |=> $stable(st_q.level));

    // R7: mute drives target to zero
    a_r7_mute_target: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> (st_q.target == '0));

    // R5: level and target stay inside the legal range
    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level <= UNITY) && (st_q.target <= UNITY));

endmodule

// File: rtl/fade_chan.sv
module fade_chan #(
    parameter int DW  = 16,
    parameter int CW  = 9,
    parameter int ZCB = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic signed [DW-1:0] smp,
    input  logic [CW-1:0]        level,
    output logic signed [DW-1:0] out
);
    localparam int PW = DW + CW + 1;
    localparam int SH = CW - 1;
    localparam logic [CW-1:0] UNITY = CW'(1) << (CW - 1);
    localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] SMIN = -PW'(64'sd1 <<< (DW - 1));

    typedef struct packed {
        logic [CW-1:0]        coef;
        logic signed [DW-1:0] out;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [ZCB-1:0]        top_bits;
    logic                  quiet;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  shifted;

    always_comb begin
        top_bits = smp[DW-1 -: ZCB];
        quiet    = (top_bits == '0) || (top_bits == '1);
        st_d     = st_q;
        prod     = '0;
        shifted  = '0;
        if (frame_stb) begin
            if (quiet) st_d.coef = level;
            prod    = PW'(smp) * $signed({1'b0, st_d.coef});
            shifted = prod >>> SH;
            if (shifted > SMAX)      st_d.out = DW'(SMAX);
            else if (shifted < SMIN) st_d.out = DW'(SMIN);
            else                     st_d.out = DW'(shifted);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.coef <= UNITY;
            st_q.out  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.out;

    function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
        return (v < 0) ? (DW+1)'(-(DW+1)'(v)) : (DW+1)'(v);
    endfunction

    // R6: a loud sample leaves the coefficient untouched
    a_r6_loud_keeps_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !quiet) |=> $stable(st_q.coef));

    // R6: without a frame the coefficient does not move
    a_r6_idle_keeps_coef: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(st_q.coef));

    // R9: output magnitude bounded by input magnitude
    a_r9_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (mag(st_q.out) <= mag($past(smp))));

endmodule

// File: rtl/stereo_fade_att.sv
module stereo_fade_att #(
    parameter int DW  = 16,
    parameter int CW  = 9,
    parameter int ZCB = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    input  logic                 cmd_up,
    input  logic                 cmd_down,
    input  logic                 cmd_set,
    input  logic [CW-1:0]        att_code,
    input  logic                 mute,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r,
    output logic                 out_vld
);
    localparam int NCH = 2;

    logic [CW-1:0]        level;
    logic signed [DW-1:0] ch_in  [NCH];
    logic signed [DW-1:0] ch_out [NCH];
    logic                 vld_d, vld_q;

    fade_level_ctrl #(.CW(CW)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .cmd_up   (cmd_up),
        .cmd_down (cmd_down),
        .cmd_set  (cmd_set),
        .att_code (att_code),
        .mute     (mute),
        .level    (level)
    );

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        fade_chan #(.DW(DW), .CW(CW), .ZCB(ZCB)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_stb(frame_stb),
            .smp      (ch_in[c]),
            .level    (level),
            .out      (ch_out[c])
        );
    end

    always_comb vld_d = frame_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
    end

    assign out_l   = ch_out[0];
    assign out_r   = ch_out[1];
    assign out_vld = vld_q;

    // R8: outputs only move in the cycle after a frame strobe
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(out_l) && $stable(out_r)));

    // R8: valid follows the strobe by exactly one cycle
    a_r8_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> out_vld);

endmodule

// File: tb/sim_stereo_fade_att.sv
module sim_stereo_fade_att;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic cmd_up = 1'b0, cmd_down = 1'b0, cmd_set = 1'b0, mute = 1'b0;
    logic [8:0] att_code = '0;
    logic signed [15:0] out_l, out_r;
    logic out_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int m_level, m_target, m_coef_l, m_coef_r;
    bit m_mute;

    always #2.5ns clk = ~clk;

    stereo_fade_att u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .in_l(in_l), .in_r(in_r),
        .cmd_up(cmd_up), .cmd_down(cmd_down), .cmd_set(cmd_set),
        .att_code(att_code), .mute(mute),
        .out_l(out_l), .out_r(out_r), .out_vld(out_vld)
    );

    function automatic bit is_quiet(input logic signed [15:0] s);
        return (s[15:9] == 7'h00) || (s[15:9] == 7'h7f);
    endfunction

    function automatic int scale(input int s, input int c);
        int p;
        p = s * c;
        return p >>> 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one frame; commands never share a cycle with a strobe
    task automatic frame(input int l, input int r, input string req);
        int el, er;
        @(negedge clk);
        frame_stb = 1'b1;
        in_l = 16'(l);
        in_r = 16'(r);
        if (is_quiet(16'(l))) m_coef_l = m_level;   // R6
        if (is_quiet(16'(r))) m_coef_r = m_level;
        el = scale(l, m_coef_l);
        er = scale(r, m_coef_r);
        if (m_level < m_target) m_level++;          // R3
        else if (m_level > m_target) m_level--;
        @(negedge clk);
        frame_stb = 1'b0;
        chk({req, " left"}, int'(out_l), el);
        chk({req, " right"}, int'(out_r), er);
        chk("R8 vld", int'(out_vld), 1);
        @(negedge clk);
        chk("R8 hold left", int'(out_l), el);
        chk("R8 vld low", int'(out_vld), 0);
    endtask

    task automatic command(input int kind, input int code);
        int cc;
        @(negedge clk);
        cmd_up = (kind == 1);
        cmd_down = (kind == 2);
        cmd_set = (kind == 3);
        att_code = 9'(code);
        cc = (code > 256) ? 256 : code;
        if (!m_mute) begin
            if (kind == 3) begin m_target = cc; m_level = cc; end   // R5
            else if (kind == 1) m_target = 256;                      // R4
            else if (kind == 2) m_target = 0;
        end
        @(negedge clk);
        cmd_up = 1'b0; cmd_down = 1'b0; cmd_set = 1'b0;
    endtask

    task automatic set_mute(input bit v);
        @(negedge clk);
        mute = v;
        m_mute = v;
        if (v) m_target = 0;   // R7
    endtask

    // bring both coefficients to the level with a quiet frame
    task automatic settle(input string req);
        frame(100, -100, req);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_level = 256; m_target = 256; m_coef_l = 256; m_coef_r = 256; m_mute = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset left", int'(out_l), 0);
        chk("R1 reset right", int'(out_r), 0);
        chk("R1 reset vld", int'(out_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle vld", int'(out_vld), 0);

        // R1/R2: unity passes loud samples through unchanged
        frame(-32768, 32767, "R2 unity extremes");
        frame(12345, -4321, "R2 unity");

        // R5: direct set to 60, quiet frame picks it up, then loud sample
        command(3, 60);
        settle("R5 set 60");
        frame(16384, -16384, "R2 code 60");
        chk("R2 code60 value", int'(out_l), 3840);
        frame(-1, 1, "R2 floor negative");

        // R5: clamp above unity
        command(3, 400);
        settle("R5 clamp");
        frame(20000, -20000, "R5 clamp gain");

        // R6: loud samples keep old coef while level ramps
        command(3, 200);
        frame(30000, 5, "R6 left loud right quiet");
        frame(-30000, -30000, "R6 both loud");
        command(2, 0);
        repeat (10) frame(30000, -300, "R3 ramp down");
        // R4: reverse mid-fade
        command(1, 0);
        repeat (20) frame(-200, 25000, "R4 reverse");

        // R7: mute ramps to zero, commands ignored
        set_mute(1);
        command(3, 256);
        command(1, 0);
        repeat (260) frame(50, -50, "R7 mute fade");
        frame(32767, -32768, "R7 zero coef");
        chk("R7 silent", int'(out_l), 0);
        set_mute(0);

        // R3: settled level stays at target
        command(3, 128);
        repeat (5) frame(256, -256, "R3 settled");
        chk("R3 settled value", int'(out_l), 128);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int l, r, k;
            k = int'($urandom_range(0, 15));
            if (k == 0) command(1, 0);
            else if (k == 1) command(2, 0);
            else if (k == 2) command(3, int'($urandom_range(0, 300)));
            else if (k == 3) set_mute(!m_mute);
            if ($urandom_range(0, 1) == 0) l = int'($urandom_range(0, 1023)) - 512;
            else l = int'($signed(16'($urandom)));
            if ($urandom_range(0, 1) == 0) r = int'($urandom_range(0, 1023)) - 512;
            else r = int'($signed(16'($urandom)));
            frame(l, r, "R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule